// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (Bus Master)

This block sends stereo audio over a three-wire serial link and owns the link's timing. From the system clock it produces a divided bit clock and a channel-select line. Sample pairs arrive as parallel two's-complement words through a valid/ready handshake. The block shifts them onto one serial data line, left channel then right, with the most significant bit first.

One stereo pair is taken per frame, on the edge that opens the left slot. The bit-clock division, the sample width and the number of bit periods per channel slot are compile-time parameters. When a slot is wider than the sample, the bits after the LSB are zero. If no pair is offered when the block needs one, it sends a silent frame and flags the miss.

Data and channel-select change only where the bit clock falls, so a receiver samples on the rising edge. The MSB of each channel follows the channel-select transition by one bit period.

Top module: `stereo_ser_tx`

## Requirements
- R1: While `rst` is high, at each clock edge `bclk`, `ws`, `sd`, `in_ready` and `underrun` are all driven low.
- R2: `bclk` is `clk` divided by DIV (even, at least 2). It stays high for DIV/2 clock cycles and then low for DIV/2 clock cycles.
- R3: `ws` and `sd` change only on the `clk` edge at which `bclk` goes from 1 to 0.
- R4: A frame is 2*SLOT_W bit periods. `ws` = 0 selects the left channel and `ws` = 1 the right. `ws` holds the channel of the slot in progress, except in that slot's last bit period, where it already shows the next channel.
- R5: Each channel's sample goes out unmodified, as SAMPLE_W two's-complement bits, MSB first. Its MSB is on `sd` in the bit period that follows the bit period in which `ws` changed.
- R6: When SLOT_W > SAMPLE_W, the last SLOT_W-SAMPLE_W bit periods of each slot carry 0 on `sd`.
- R7: `in_ready` is high for exactly one `clk` cycle per frame, every 2*SLOT_W*DIV cycles, on the edge that opens the left slot. A pair presented with `in_valid` high in that cycle is sent, left then right, in the frame that begins at once.
- R8: If `in_valid` is low while `in_ready` is high, both slots of that frame carry zeros. `underrun` is then high for the single `clk` cycle that follows.
- R9: A pair with `in_valid` high while `in_ready` is low has no effect: it is not sent unless it is still valid when `in_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A stereo pair is offered |
| in_ready | output | 1 | The pair is taken on this clock edge |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Channel select: 0 left, 1 right |
| sd | output | 1 | Serial data, MSB first |
| underrun | output | 1 | One-cycle pulse when a frame had no sample |

## Verification
- **Handshake and underrun timing.** `in_ready` is a combinational decode of registered state, so the bench reads it between edges. The pair accepted on the next edge is pushed into the scoreboard at once. `underrun` is due in the very next clock cycle and is compared one sample later.
- **Serial bit timing.** Each serial bit becomes valid one `clk` cycle after the falling-edge tick that launches it. The monitor therefore captures `sd` and `ws` at each observed `bclk` rise, DIV/2 cycles after launch. A word is complete SLOT_W rises after the previous one.
- **When expected words appear.** An accepted pair's left word finishes SLOT_W bit periods after acceptance, and the right word SLOT_W bit periods after that. The final drain check waits three whole frames before reading the queue.

// File: rtl/stereo_ser_pkg.sv
package stereo_ser_pkg;

   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

   // bits needed to count the bit periods of one stereo frame
   function automatic int frame_pos_bits(input int slot_w);
      return (2 * slot_w <= 2) ? 1 : $clog2(2 * slot_w);
   endfunction

endpackage

// File: rtl/stereo_ser_clkdiv.sv
module stereo_ser_clkdiv #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst,
   output logic bclk,
   output logic fall_tick
);
   localparam int HALF = DIV / 2;
   localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

   logic bclk_q;

   generate
      if (HALF == 1) begin : g_div2
         // toggles every system clock; every high phase ends at the next edge
         always_ff @(posedge clk) begin
            if (rst) bclk_q <= 1'b0;
            else     bclk_q <= ~bclk_q;
         end
         assign fall_tick = bclk_q;
      end else begin : g_divn
         localparam logic [HW-1:0] HLAST = HW'(HALF - 1);
         logic [HW-1:0] half_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               half_q <= '0;
               bclk_q <= 1'b0;
            end else if (half_q == HLAST) begin
               half_q <= '0;
               bclk_q <= ~bclk_q;
            end else begin
               half_q <= half_q + 1'b1;
            end
         end
         assign fall_tick = bclk_q && (half_q == HLAST);

         assert_bclk_hold_R2 : assert property (@(posedge clk) disable iff (rst)
            (half_q != HLAST) |=> $stable(bclk_q));
      end
   endgenerate

   assign bclk = bclk_q;

   assert_bclk_falls_R2 : assert property (@(posedge clk) disable iff (rst)
      fall_tick |=> !bclk);

endmodule

// File: rtl/stereo_ser_framer.sv
module stereo_ser_framer
   import stereo_ser_pkg::*;
#(
   parameter int SLOT_W = 10,
   parameter int PW     = frame_pos_bits(SLOT_W)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          fall_tick,
   output logic [PW-1:0] pos,
   output logic          ws,
   output logic          open_left,
   output logic          open_right
);
   localparam logic [PW-1:0] LAST     = PW'(2 * SLOT_W - 1);
   localparam logic [PW-1:0] LEFT_END = PW'(SLOT_W - 1);

   logic [PW-1:0] pos_q, next_pos;
   logic          ws_q, ws_next;

   assign next_pos = (pos_q == LAST) ? '0 : pos_q + 1'b1;
   // select leads the data by one bit period: high from the last left bit
   // up to, but not including, the last right bit
   assign ws_next  = (next_pos >= LEFT_END) && (next_pos != LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q <= LAST;
         ws_q  <= CH_LEFT;
      end else if (fall_tick) begin
         pos_q <= next_pos;
         ws_q  <= ws_next;
      end
   end

   assign pos        = pos_q;
   assign ws         = ws_q;
   assign open_left  = fall_tick && (pos_q == LAST);
   assign open_right = fall_tick && (pos_q == LEFT_END);

   assert_ws_left_at_msb_R4 : assert property (@(posedge clk) disable iff (rst)
      open_left |=> (ws == CH_LEFT));
   assert_ws_right_at_msb_R4 : assert property (@(posedge clk) disable iff (rst)
      open_right |=> (ws == CH_RIGHT));

endmodule

// File: rtl/stereo_ser_shifter.sv
module stereo_ser_shifter #(
   parameter int SAMPLE_W = 8,
   parameter int SLOT_W   = 10
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                fall_tick,
   input  logic                open_left,
   input  logic                open_right,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   output logic                in_ready,
   output logic                sd,
   output logic                underrun
);
   localparam int PAD = SLOT_W - SAMPLE_W;

   logic [SLOT_W-1:0]   sh_q, left_slot, right_slot;
   logic [SAMPLE_W-1:0] r_hold_q;
   logic                take, under_q;

   generate
      if (PAD == 0) begin : g_exact
         assign left_slot  = in_left;
         assign right_slot = r_hold_q;
      end else begin : g_pad
         assign left_slot  = {in_left,  {PAD{1'b0}}};
         assign right_slot = {r_hold_q, {PAD{1'b0}}};
      end
   endgenerate

   assign in_ready = open_left;
   assign take     = open_left && in_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q     <= '0;
         r_hold_q <= '0;
         under_q  <= 1'b0;
      end else begin
         under_q <= open_left && !in_valid;
         if (open_left) begin
            sh_q     <= take ? left_slot : '0;
            r_hold_q <= take ? in_right  : '0;
         end else if (open_right) begin
            sh_q <= right_slot;
         end else if (fall_tick) begin
            sh_q <= {sh_q[SLOT_W-2:0], 1'b0};
         end
      end
   end

   assign sd       = sh_q[SLOT_W-1];
   assign underrun = under_q;

   assert_ready_single_R7 : assert property (@(posedge clk) disable iff (rst)
      in_ready |=> !in_ready);
   assert_underrun_single_R8 : assert property (@(posedge clk) disable iff (rst)
      underrun |=> !underrun);
   assert_underrun_silent_R8 : assert property (@(posedge clk) disable iff (rst)
      underrun |-> !sd);

endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
   import stereo_ser_pkg::*;
#(
   parameter int DIV      = 4,
   parameter int SAMPLE_W = 16,
   parameter int SLOT_W   = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   output logic                bclk,
   output logic                ws,
   output logic                sd,
   output logic                underrun
);
   localparam int PW = frame_pos_bits(SLOT_W);

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("stereo_ser_tx: DIV must be even and at least 2");
      end
      if (SAMPLE_W < 1 || SLOT_W < SAMPLE_W || SLOT_W < 2) begin : g_bad_slot
         $error("stereo_ser_tx: need SLOT_W >= SAMPLE_W >= 1 and SLOT_W >= 2");
      end
   endgenerate

   logic          fall_tick, open_left, open_right;
   logic [PW-1:0] pos;

   stereo_ser_clkdiv #(.DIV(DIV)) u_clkdiv (
      .clk       (clk),
      .rst       (rst),
      .bclk      (bclk),
      .fall_tick (fall_tick)
   );

   stereo_ser_framer #(.SLOT_W(SLOT_W), .PW(PW)) u_framer (
      .clk        (clk),
      .rst        (rst),
      .fall_tick  (fall_tick),
      .pos        (pos),
      .ws         (ws),
      .open_left  (open_left),
      .open_right (open_right)
   );

   stereo_ser_shifter #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_shifter (
      .clk        (clk),
      .rst        (rst),
      .fall_tick  (fall_tick),
      .open_left  (open_left),
      .open_right (open_right),
      .in_valid   (in_valid),
      .in_left    (in_left),
      .in_right   (in_right),
      .in_ready   (in_ready),
      .sd         (sd),
      .underrun   (underrun)
   );

   assert_reset_idle_R1 : assert property (@(posedge clk)
      rst |=> (!bclk && !ws && !sd && !underrun));
   assert_ws_on_fall_R3 : assert property (@(posedge clk) disable iff (rst)
      !$stable(ws) |-> $fell(bclk));
   assert_sd_on_fall_R3 : assert property (@(posedge clk) disable iff (rst)
      !$stable(sd) |-> $fell(bclk));

   generate
      if (SLOT_W > SAMPLE_W) begin : g_pad_check
         logic [PW-1:0] slot_idx;
         assign slot_idx = (pos >= PW'(SLOT_W)) ? pos - PW'(SLOT_W) : pos;
         assert_pad_zero_R6 : assert property (@(posedge clk) disable iff (rst)
            (slot_idx >= PW'(SAMPLE_W)) |-> !sd);
      end
   endgenerate

endmodule

// File: tb/stereo_ser_tx_bench.sv
module stereo_ser_tx_bench;
   localparam int DIV   = 4;
   localparam int SW    = 8;
   localparam int SL    = 10;
   localparam int HALF  = DIV / 2;
   localparam int FRAME = 2 * SL * DIV;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [SW-1:0] in_left = '0, in_right = '0;
   logic          in_ready, bclk, ws, sd, underrun;

   always #2 clk = ~clk;

   stereo_ser_tx #(.DIV(DIV), .SAMPLE_W(SW), .SLOT_W(SL)) u_stereo_ser_tx (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_left(in_left), .in_right(in_right),
      .bclk(bclk), .ws(ws), .sd(sd), .underrun(underrun)
   );

   int checks = 0, errors = 0;
   logic [SW-1:0] exp_q[$];
   string         tag_q[$];
   bit            r9_window = 1'b0;
   bit            done = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // handshake observer: pushes expected words and checks ready spacing / underrun
   int cyc = 0, last_ready = -1;
   bit under_due = 1'b0;
   always @(negedge clk) begin
      if (!rst) begin
         cyc++;
         check(underrun == under_due, "R8", "underrun pulse", underrun, under_due);
         under_due = in_ready && !in_valid;
         if (in_ready) begin
            if (last_ready >= 0)
               check(cyc - last_ready == FRAME, "R7", "ready spacing",
                     cyc - last_ready, FRAME);
            last_ready = cyc;
            if (in_valid) begin
               exp_q.push_back(in_left);  tag_q.push_back("R5");
               exp_q.push_back(in_right); tag_q.push_back("R5");
            end else begin
               exp_q.push_back('0); tag_q.push_back(r9_window ? "R9" : "R8");
               exp_q.push_back('0); tag_q.push_back(r9_window ? "R9" : "R8");
            end
         end
      end
   end

   // serial monitor: samples at bclk rises, as a receiver would
   logic          prev_bclk = 1'b0, prev_ws = 1'b0, prev_sd = 1'b0;
   int            run = 0, idx = 0, words = 0;
   bit            toggled = 1'b0, started = 1'b0, chan = 1'b0;
   logic [SL-1:0] word = '0;
   logic [SW-1:0] e;
   string         t;
   always @(negedge clk) begin
      if (!rst) begin
         if (ws != prev_ws || sd != prev_sd)
            check(prev_bclk && !bclk, "R3", "ws/sd moved off a bclk fall", bclk, 0);
         if (bclk == prev_bclk) run++;
         else begin
            if (toggled) check(run == HALF, "R2", "bclk phase length", run, HALF);
            toggled = 1'b1;
            run = 1;
         end
         if (!prev_bclk && bclk) begin
            if (!started) begin
               started = 1'b1; chan = 1'b0; idx = 0;
            end else begin
               if (idx < SL - 1) check(ws == chan, "R4", "ws inside slot", ws, chan);
               word[SL-1-idx] = sd;
               idx++;
               if (idx == SL) begin
                  check(ws != chan, "R5", "ws leads next MSB by one bit", ws, !chan);
                  check(word[SL-SW-1:0] == '0, "R6", "pad bits", word[SL-SW-1:0], 0);
                  if (exp_q.size() == 0) check(0, "R7", "word without handshake", word, 0);
                  else begin
                     e = exp_q.pop_front();
                     t = tag_q.pop_front();
                     check(word[SL-1 -: SW] == e, t, chan ? "right word" : "left word",
                           word[SL-1 -: SW], e);
                  end
                  words++;
                  chan = !chan;
                  idx = 0;
               end
            end
         end
      end
      prev_bclk = bclk; prev_ws = ws; prev_sd = sd;
   end

   task automatic send_pair(input logic [SW-1:0] l, input logic [SW-1:0] r);
      @(posedge clk); #1;
      in_valid = 1'b1; in_left = l; in_right = r;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: idle outputs under reset
      check(!bclk,     "R1", "bclk in reset",     bclk, 0);
      check(!ws,       "R1", "ws in reset",       ws, 0);
      check(!sd,       "R1", "sd in reset",       sd, 0);
      check(!in_ready, "R1", "ready in reset",    in_ready, 0);
      check(!underrun, "R1", "underrun in reset", underrun, 0);
      @(posedge clk); #1 rst = 1'b0;
      // first frame has no sample offered: R8 silent frame
      repeat (FRAME + 10) @(posedge clk);
      send_pair(8'h80, 8'h7F);
      send_pair(8'hA5, 8'h5A);
      send_pair(8'h01, 8'hFF);
      // R9: valid raised and dropped while ready is low
      @(posedge clk); #1;
      r9_window = 1'b1;
      in_valid = 1'b1; in_left = 8'h3C; in_right = 8'hC3;
      repeat (20) @(posedge clk);
      #1 in_valid = 1'b0;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1 r9_window = 1'b0;
      send_pair(8'hFF, 8'h00);
      send_pair(8'h96, 8'h69);
      repeat (3 * FRAME) @(posedge clk);
      @(negedge clk);
      check(exp_q.size() <= 2, "R7", "scoreboard drained", exp_q.size(), 2);
      check(words >= 14, "R5", "words received", words, 14);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule